// File: doc/BRIEF.md
# Shared-Timebase PWM Bank

This block drives a set of pulse-width-modulated outputs from a single free-running counter of `CNT_W` bits, 16 by default. The counter advances on a timer tick. A prescaler produces that tick from the system clock as a one-cycle enable, either every `div_value` cycles or, in direct mode, on every cycle. One period lasts 2^CNT_W ticks. Each channel holds a value that gives the number of ticks at the start of every period during which its output is low. For the rest of the period the output is high. Because every channel reads the same counter, all channels run at one frequency and their falling edges land on the same clock cycle.

Software writes a channel's value through a one-word write port, `wr_en` / `wr_sel` / `wr_value`. The value goes into a shadow register and becomes active only at the next counter rollover, so a period is never cut short. A channel whose enable input rises starts at the next rollover. When the enable falls, the output goes low in the same cycle.

Timing convention used below: cycle 0 is the first clock cycle after reset is released. With effective divisor d, a tick occurs in cycle k when k mod d equals d−1. The counter value in cycle k is floor(k/d) mod 2^CNT_W. A rollover is a tick taken while the counter holds its maximum value.

Top module: `pwm_bank`

## Requirements
- R1: With `div_bypass` low, the effective divisor d is `div_value`, and a value of 0 means 2^DIV_W (256 by default). Each period lasts 2^CNT_W × d clock cycles, and the counter follows the timing convention above.
- R2: With `div_bypass` high, a tick occurs on every clock cycle (d = 1), whatever `div_value` holds.
- R3: In a running, enabled channel with active value V, the output is low while the counter is below V and high while the counter is V or above. A falling edge therefore occurs only when the counter returns to 0.
- R4: An active value of 0 gives a constant high output. The maximum value 2^CNT_W−1 gives exactly one high tick per period, at counter value 2^CNT_W−1.
- R5: All channels share one counter. Channels that are enabled and have nonzero values fall low in the same clock cycle, which is the first cycle of a period.
- R6: When a channel's enable is high but the channel has not yet passed a rollover with the enable high, its output is low. The channel starts with the cycle that follows the rollover.
- R7: A low enable forces the channel output low in the same cycle. To run again, the channel waits for a fresh rollover, as in R6.
- R8: A write changes only the shadow value. The active value is reloaded from the shadow at each rollover. A write made in the rollover cycle itself applies to the period that begins next.
- R9: Reset is synchronous and active low. It forces all outputs low, sets the counter and prescaler to 0, clears every channel's running state and sets every value to 0. A channel whose enable is held through reset therefore waits for the first rollover.
- R10: A write with `wr_sel` = i affects only channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_bypass | input | 1 | High: one tick per clock; low: divide by `div_value` |
| div_value | input | DIV_W | Prescaler divisor, 0 means 2^DIV_W |
| ch_enable | input | NCH | Per-channel enable |
| wr_en | input | 1 | Write strobe for a channel value |
| wr_sel | input | SEL_W | Channel index of the write |
| wr_value | input | CNT_W | Low-tick count written to the shadow |
| pwm_out | output | NCH | PWM outputs |

## Verification
The main function is exercised with several kinds of value. Zero values separate constant high from any modulation. The maximum value tests the single-tick high phase. Equal values on two channels show whether the channels stay identical. Unequal mid-range values show that the falling edges align while the rising edges differ. Divisors of 1, 3 and 0 (meaning 256), and direct mode with a nonunit divisor loaded, tell a correct prescaler apart from an off-by-one or a wrong decoding of 0. Writes are placed mid-period and in the rollover cycle, and enables are dropped and raised mid-period. Together these separate shadow loading at rollover from immediate loading, and a deferred start from an immediate one.

// File: rtl/pwm_bank_pkg.sv
// Package: types shared by the PWM bank modules.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_bank_pkg;

    // Per-cycle timebase events that the shared counter hands to every channel.
    typedef struct packed {
        logic tick;   // timer tick in this cycle
        logic wrap;   // tick taken at the counter maximum (rollover)
    } tb_evt_t;

endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Produces a one-cycle tick enable every div_i cycles (0 decodes as 2^DIV_W),
// or on every cycle when bypass_i is high. No derived clock is generated.
// Assumes: div_i is normally changed only while idle or in reset; a lowered
// divisor is honoured at once because the compare uses >=.
module pwm_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] limit;

    // Terminal count: divisor minus one, so 0 wraps to all ones (2^DIV_W).
    always_comb limit = div_i - 1'b1;

    // Tick when bypassed or when the cycle count reaches the terminal count.
    always_comb tick_o = bypass_i | (pcnt >= limit);

    // Cycle counter inside one tick interval.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (tick_o) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    // R1: once the divisor has been stable for a cycle, the count stays in range.
    assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && $stable(div_i)) |-> (pcnt <= limit));

endmodule

// File: rtl/pwm_timebase.sv
// Module: pwm_timebase
// Shared free-running period counter of CNT_W bits, advanced by tick_i.
// Flags the rollover as a tick taken at the maximum count.
// Assumes: tick_i is a one-cycle enable in the clk domain.
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Rollover flag: last tick of the period.
    always_comb wrap_o = tick_i && (cnt_o == CNT_MAX);

    // Period counter, wraps naturally at 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (tick_i) cnt_o <= cnt_o + 1'b1;
    end

    // R1: the counter only moves on a tick.
    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));

    // R1: each tick advances the counter by exactly one, modulo the period.
    assert_step_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel
// One PWM output: low while the shared count is below the active value,
// high afterwards. The value is shadowed and loaded at rollover; the channel
// starts at a rollover and stops at once when its enable falls.
// Assumes: cnt_i and wrap_i come from the shared timebase.
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wrap_i,
    output logic             pwm_o
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             run_q;

    // Shadow register: takes every write for this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (wr_i) shadow_q <= wr_data_i;
    end

    // Active compare value: reloaded at rollover, a same-cycle write passes through.
    always_ff @(posedge clk) begin
        if (!rst_n)      active_q <= '0;
        else if (wrap_i) active_q <= wr_i ? wr_data_i : shadow_q;
    end

    // Running flag: set at a rollover with enable high, cleared whenever enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (!en_i)  run_q <= 1'b0;
        else if (wrap_i) run_q <= 1'b1;
    end

    // Output: low phase first, then high; enable gates it without delay.
    always_comb pwm_o = run_q && en_i && (cnt_i >= active_q);

    // R6: a channel begins running only right after a rollover.
    assert_start_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(wrap_i));

    // R8: the active value never changes between rollovers.
    assert_active_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(active_q));

    // R5: with the channel still enabled, a falling edge sits at count zero.
    assert_fall_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_o) && en_i) |-> (cnt_i == '0));

endmodule

// File: rtl/pwm_bank.sv
// Module: pwm_bank (top)
// NCH PWM channels sharing one prescaler and one period counter, so all
// outputs share frequency and falling-edge timing. Values are written through
// a single select/data port into per-channel shadows.
// Assumes: synchronous active-low reset; wr_sel beyond NCH-1 is ignored.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int DIV_W = 8,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_bypass,
    input  logic [DIV_W-1:0] div_value,
    input  logic [NCH-1:0]   ch_enable,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_value,
    output logic [NCH-1:0]   pwm_out
);

    logic             tick_w;
    logic             wrap_w;
    logic [CNT_W-1:0] cnt_w;
    tb_evt_t          evt;

    // Bundle the timebase events handed to the channels.
    always_comb evt = '{tick: tick_w, wrap: wrap_w};

    pwm_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass_i (div_bypass),
        .div_i    (div_value),
        .tick_o   (tick_w)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (evt.tick),
        .cnt_o  (cnt_w),
        .wrap_o (wrap_w)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ch_enable[i]),
            .wr_i      (wr_en && (wr_sel == SEL_W'(i))),
            .wr_data_i (wr_value),
            .cnt_i     (cnt_w),
            .wrap_i    (evt.wrap),
            .pwm_o     (pwm_out[i])
        );
    end

    // R9: outputs are all low in the cycle after a reset edge.
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));

endmodule

// File: tb/pwm_bank_bench.sv
// Bench for pwm_bank: a per-cycle reference model pushes expected outputs
// into a scoreboard queue; a monitor pops and compares half a cycle later.
module pwm_bank_bench;

    localparam int NCH   = 4;
    localparam int CNT_W = 5;
    localparam int DIV_W = 8;
    localparam int SEL_W = 2;
    localparam int P     = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_bypass = 1'b1;
    logic [DIV_W-1:0] div_value = '0;
    logic [NCH-1:0]   ch_enable = '0;
    logic             wr_en = 1'b0;
    logic [SEL_W-1:0] wr_sel = '0;
    logic [CNT_W-1:0] wr_value = '0;
    logic [NCH-1:0]   pwm_out;

    always #2 clk = ~clk;

    pwm_bank #(.NCH(NCH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_pwm_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_bypass (div_bypass),
        .div_value  (div_value),
        .ch_enable  (ch_enable),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_value   (wr_value),
        .pwm_out    (pwm_out)
    );

    typedef struct {
        bit             chk;
        logic [NCH-1:0] exp;
        string          req;
        int             cyc;
    } sb_item_t;

    sb_item_t sb_q[$];
    int       n_tests = 0;
    int       n_fail  = 0;
    int       cyc     = 0;
    int       m_shadow[NCH];
    int       m_act[NCH];
    bit       m_run[NCH];
    string    cur_req = "R9";

    function automatic int eff_div();
        if (div_bypass) return 1;
        if (div_value == 0) return 1 << DIV_W;
        return int'(div_value);
    endfunction

    // Reference model: expected outputs for this cycle, then state update.
    always @(negedge clk) begin : model
        sb_item_t it;
        int d;
        int pos;
        bit wrap;
        it.req = cur_req;
        it.cyc = cyc;
        it.exp = '0;
        it.chk = 1'b0;
        if (!rst_n) begin
            cyc = 0;
            for (int c = 0; c < NCH; c++) begin
                m_shadow[c] = 0; m_act[c] = 0; m_run[c] = 1'b0;
            end
        end else begin
            d    = eff_div();
            pos  = (cyc / d) % P;
            wrap = ((cyc % d) == d - 1) && (pos == P - 1);
            it.chk = 1'b1;
            for (int c = 0; c < NCH; c++)
                it.exp[c] = m_run[c] && ch_enable[c] && (pos >= m_act[c]);
            for (int c = 0; c < NCH; c++) begin
                if (wrap)
                    m_act[c] = (wr_en && int'(wr_sel) == c) ? int'(wr_value) : m_shadow[c];
                if (!ch_enable[c]) m_run[c] = 1'b0;
                else if (wrap)     m_run[c] = 1'b1;
            end
            if (wr_en) m_shadow[wr_sel] = int'(wr_value);
            cyc++;
        end
        sb_q.push_back(it);
    end

    // Monitor: compares the design output against the queued expectation.
    always @(negedge clk) begin : monitor
        sb_item_t it;
        #1;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            if (it.chk) begin
                n_tests++;
                if (pwm_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: pwm_out=%b expected %b",
                             it.req, it.cyc, pwm_out, it.exp);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [NCH-1:0] act_v,
                         input logic [NCH-1:0] exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: pwm_out=%b expected %b", req, act_v, exp_v);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic goto_phase(input int ph);
        int per;
        per = P * eff_div();
        do step(1); while ((cyc % per) != ph);
    endtask

    task automatic write_ch(input int ch, input int val);
        wr_en = 1'b1; wr_sel = SEL_W'(ch); wr_value = CNT_W'(val);
        step(1);
        wr_en = 1'b0;
    endtask

    // R9: reset held two edges leaves all outputs low; enables may stay high.
    task automatic do_reset(input bit byp, input int dv);
        rst_n = 1'b0;
        step(2);
        check(pwm_out == '0, "R9 reset outputs", pwm_out, '0);
        div_bypass = byp;
        div_value  = DIV_W'(dv);
        rst_n = 1'b1;
    endtask

    initial begin : stimulus
        step(1);
        // R9 / R6 / R4: enable held through reset, value 0 -> high after first rollover.
        ch_enable = 4'b0001;
        do_reset(1'b1, 0);
        cur_req = "R6/R9/R4";
        step(3 * P + 5);

        // R3 / R4 / R5: equal, mid-range and maximum values on all channels.
        cur_req = "R3/R4/R5";
        write_ch(0, 5);
        write_ch(1, 5);
        write_ch(2, 20);
        write_ch(3, P - 1);
        ch_enable = 4'b1111;
        step(2 * P);
        goto_phase(P - 1);
        #1;
        check(pwm_out == 4'b1111, "R5 last tick all high", pwm_out, 4'b1111);
        step(1);
        check(pwm_out == 4'b0000, "R5 aligned fall", pwm_out, 4'b0000);
        step(P);

        // R8 / R10: mid-period write and write in the rollover cycle.
        cur_req = "R8/R10";
        goto_phase(10);
        write_ch(2, 3);
        goto_phase(P - 1);
        write_ch(1, 12);
        step(2 * P);

        // R7 / R6: drop enable in the high phase, raise it again mid-period.
        cur_req = "R7/R6";
        goto_phase(20);
        ch_enable[2] = 1'b0;
        #1;
        check(pwm_out[2] == 1'b0, "R7 immediate disable", pwm_out, pwm_out & 4'b1011);
        step(3);
        ch_enable[2] = 1'b1;
        step(2 * P);

        // R1: divided tick with divisor 3.
        cur_req = "R1 div3";
        do_reset(1'b0, 3);
        write_ch(0, 10);
        write_ch(1, P - 1);
        step(3 * 3 * P + 10);

        // R1: divisor 1 without bypass.
        cur_req = "R1 div1";
        do_reset(1'b0, 1);
        write_ch(2, 7);
        step(2 * P + 5);

        // R1: divisor register 0 decodes as 256.
        cur_req = "R1 div256";
        do_reset(1'b0, 0);
        write_ch(0, 16);
        step(2 * P * 256 + 10);

        // R2: bypass ignores a loaded divisor.
        cur_req = "R2 bypass";
        do_reset(1'b1, 9);
        write_ch(0, 7);
        write_ch(3, 0);
        step(3 * P);

        step(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule